// File: doc/BRIEF.md
# Collapsed Value Remap Stage

This block sits on the read side of an ordinary FIFO and corrects each value as it leaves. Entries already stored in the FIFO are never rewritten. The block keeps a table with one slot for every possible data value, and each slot holds the value that its index currently stands for. Every slot starts out holding its own index, so a value passes through unchanged until a change request says otherwise.

A change request names a source value and a destination value. In one clock edge, every slot whose current content equals the source is rewritten to the destination. The table therefore stays collapsed. When one value is redirected, every older redirection that pointed at it moves along too. A popped value then needs only a single table read, however long the chain of changes behind it has grown. Many sources may share one destination, and no reverse links are kept. The lookup result is registered, so corrected data appears on the clock edge after the pop.

Top module: `remap_table`

## Requirements
- R1: After reset every slot holds its own index, so popping any value v yields v.
- R2: out_valid is high exactly in the cycle after a cycle with pop_valid high, and low otherwise.
- R3: When pop_valid is high, out_data in the next cycle equals the table slot addressed by pop_data.
- R4: When change_valid is high, every slot whose content equals change_from holds change_to after the next clock edge.
- R5: A change leaves every slot whose content differs from change_from unchanged.
- R6: Chained changes resolve fully. After 5 to 6 and then 6 to 7, a popped 5 yields 7. After a change whose source differs from its destination, no slot holds the source value.
- R7: Several sources redirected to one destination all follow a later change of that destination.
- R8: When a pop and a change happen in the same cycle, the pop is served from the table as it was before that change.
- R9: A change whose source equals its destination alters no slot.
- R10: out_data keeps its value in any cycle after a cycle without a pop.
- R11: change_from and change_to are ignored while change_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pop_valid | input | 1 | A raw value leaves the FIFO this cycle |
| pop_data | input | DATA_W | Raw value from the FIFO |
| change_valid | input | 1 | Apply a redirection this cycle |
| change_from | input | DATA_W | Value to be redirected |
| change_to | input | DATA_W | Value it now stands for |
| out_valid | output | 1 | out_data carries a corrected value |
| out_data | output | DATA_W | Corrected value |

## Verification
On every cycle, the assertions check the output valid timing, that the output holds between pops, and how each slot responds to a change. A slot that matches the source takes the destination. A slot that does not match, or that sees no request, keeps its content. After a real change no slot is left holding the source. Only the bench scenarios can show the end-to-end meaning. These cover the identity contents after reset, the full resolution of chains and fan-in redirections as seen through pops, the old-table read when a pop and a change coincide, and the absence of any effect from a change onto itself. The bench sweeps every value of a small configuration against an arithmetic model after each change.

// File: rtl/remap_pkg.sv
package remap_pkg;
   // Largest value width accepted; bounds the slot count at elaboration.
   localparam int unsigned MAX_DATA_W = 10;

   function automatic int unsigned slot_count(input int unsigned width);
      return 32'd1 << width;
   endfunction
endpackage

// File: rtl/remap_slot.sv
module remap_slot #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned INDEX  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chg_en,
   input  logic [DATA_W-1:0] chg_from,
   input  logic [DATA_W-1:0] chg_to,
   output logic [DATA_W-1:0] value
);
   localparam logic [DATA_W-1:0] IDENT = DATA_W'(INDEX);

   logic hit;
   assign hit = chg_en && (value == chg_from);

   always_ff @(posedge clk) begin
      if (!rst_n)
         value <= IDENT;
      else if (hit)
         value <= chg_to;
   end

   // A matching slot takes the destination
   assert_rewrite_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (chg_en && value == chg_from) |=> value == $past(chg_to));

   // A non-matching slot keeps its content
   assert_keep_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (chg_en && value != chg_from) |=> $stable(value));

   // After a real change the source value is gone from every slot
   assert_collapse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (chg_en && chg_from != chg_to) |=> value != $past(chg_from));

   // Without a request the slot does not move
   assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !chg_en |=> $stable(value));
endmodule

// File: rtl/remap_lookup.sv
module remap_lookup #(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned ENTRIES = 256
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [ENTRIES-1:0][DATA_W-1:0]  tbl,
   input  logic                            rd_en,
   input  logic [DATA_W-1:0]               rd_idx,
   output logic                            out_valid,
   output logic [DATA_W-1:0]               out_data
);
   logic [DATA_W-1:0] sel;
   assign sel = tbl[rd_idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= rd_en;
         if (rd_en)
            out_data <= sel;
      end
   end

   assert_valid_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> out_valid);

   assert_valid_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !out_valid);

   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(out_data));
endmodule

// File: rtl/remap_table.sv
module remap_table #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pop_valid,
   input  logic [DATA_W-1:0] pop_data,
   input  logic              change_valid,
   input  logic [DATA_W-1:0] change_from,
   input  logic [DATA_W-1:0] change_to,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data
);
   import remap_pkg::*;

   localparam int unsigned ENTRIES = slot_count(DATA_W);

   if (DATA_W < 1 || DATA_W > MAX_DATA_W) begin : g_bad_width
      $error("remap_table: DATA_W out of supported range");
   end

   logic [ENTRIES-1:0][DATA_W-1:0] tbl;

   for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
      remap_slot #(
         .DATA_W(DATA_W),
         .INDEX (i)
      ) u_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .chg_en  (change_valid),
         .chg_from(change_from),
         .chg_to  (change_to),
         .value   (tbl[i])
      );
   end

   // The read path sees the table before this cycle's change (R8)
   remap_lookup #(
      .DATA_W (DATA_W),
      .ENTRIES(ENTRIES)
   ) u_lookup (
      .clk      (clk),
      .rst_n    (rst_n),
      .tbl      (tbl),
      .rd_en    (pop_valid),
      .rd_idx   (pop_data),
      .out_valid(out_valid),
      .out_data (out_data)
   );
endmodule

// File: tb/sim_remap_table.sv
`timescale 1ns/1ps
module sim_remap_table;
   localparam int W = 4;
   localparam int N = 1 << W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pop_valid = 1'b0;
   logic [W-1:0] pop_data = '0;
   logic change_valid = 1'b0;
   logic [W-1:0] change_from = '0;
   logic [W-1:0] change_to = '0;
   logic out_valid;
   logic [W-1:0] out_data;

   int tests = 0;
   int fails = 0;
   logic [W-1:0] model [N];

   always #4 clk = ~clk;

   remap_table #(.DATA_W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .pop_valid(pop_valid), .pop_data(pop_data),
      .change_valid(change_valid), .change_from(change_from),
      .change_to(change_to), .out_valid(out_valid), .out_data(out_data)
   );

   task automatic check(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic pop_chk(input logic [W-1:0] v, input string req);
      pop_valid = 1'b1;
      pop_data  = v;
      @(negedge clk);
      pop_valid = 1'b0;
      check({req, " valid"}, out_valid, 1);
      check(req, out_data, model[v]);
   endtask

   task automatic sweep(input string req);
      for (int v = 0; v < N; v++) pop_chk(W'(v), req);
   endtask

   task automatic model_change(input logic [W-1:0] f, input logic [W-1:0] t);
      for (int v = 0; v < N; v++) if (model[v] == f) model[v] = t;
   endtask

   task automatic change(input logic [W-1:0] f, input logic [W-1:0] t);
      change_valid = 1'b1;
      change_from  = f;
      change_to    = t;
      @(negedge clk);
      change_valid = 1'b0;
      model_change(f, t);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      tests++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [7:0] lfsr;
      logic [W-1:0] last;
      for (int v = 0; v < N; v++) model[v] = W'(v);
      repeat (3) @(negedge clk);
      check("R2 reset valid", out_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 and R3: identity after reset, exhaustive
      sweep("R1");

      // R2 and R10: idle cycle after a pop
      pop_chk(4'd3, "R3");
      last = out_data;
      @(negedge clk);
      check("R2 idle", out_valid, 0);
      check("R10 hold", out_data, last);

      // R6 chain
      change(4'd5, 4'd6);
      pop_chk(4'd5, "R6 first");
      change(4'd6, 4'd7);
      pop_chk(4'd5, "R6 chain");
      check("R6 value", out_data, 7);
      sweep("R5");

      // R7 fan-in then move target
      change(4'd1, 4'd9);
      change(4'd2, 4'd9);
      change(4'd3, 4'd9);
      change(4'd9, 4'd12);
      pop_chk(4'd1, "R7");
      check("R7 value", out_data, 12);
      pop_chk(4'd2, "R7");
      pop_chk(4'd3, "R7");
      pop_chk(4'd9, "R7");
      check("R7 target", out_data, 12);

      // R9 self change
      change(4'd4, 4'd4);
      change(4'd12, 4'd12);
      sweep("R9");

      // R11 requests with valid low
      change_from = 4'd12;
      change_to   = 4'd0;
      @(negedge clk);
      change_from = 4'd0;
      change_to   = 4'd15;
      @(negedge clk);
      sweep("R11");

      // R8 pop and change in the same cycle
      pop_valid    = 1'b1;
      pop_data     = 4'd1;
      change_valid = 1'b1;
      change_from  = 4'd12;
      change_to    = 4'd14;
      @(negedge clk);
      pop_valid    = 1'b0;
      change_valid = 1'b0;
      check("R8 valid", out_valid, 1);
      check("R8 old table", out_data, 12);
      model_change(4'd12, 4'd14);
      pop_chk(4'd1, "R8 new table");
      check("R8 updated", out_data, 14);

      // R4 and R5: pseudo-random change stream with full sweeps
      lfsr = 8'hA5;
      for (int k = 0; k < 40; k++) begin
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         change(lfsr[3:0], lfsr[7:4]);
         sweep("R4");
      end

      // R1 again after a second reset
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      for (int v = 0; v < N; v++) model[v] = W'(v);
      sweep("R1 rereset");

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule